// File: doc/BRIEF.md
# Second-Operand Barrel Shifter with Carry Flag Output

This block is the purely combinational shift stage that sits in front of the ALU in a processor datapath. It takes a 32-bit operand and applies one of five shift kinds to it: logical left, logical right, arithmetic right, rotate right, or a one-bit rotate through the carry flag. The shift length is an 8-bit value. Lengths of 32 and above are resolved exactly, both in the shifted value and in the carry bit the shift produces.

Alongside the result the block reports a carry-out and a carry-valid bit. Carry-valid tells the flag logic downstream whether the carry flag should be written. When carry-valid is low, the carry-out simply repeats the incoming carry, so the consumer can always take the carry-out as the next carry value. A control module decodes the kind and the length into a small set of strobes. A datapath module performs the shift as a chain of logarithmic stages.

Top module: `barrel_shifter_top`

## Requirements
- R1: With a length of 0 and a kind of 0, 1, 2 or 3, `result` equals `operand`, `carryValid` is 0 and `carryOut` equals `carryIn`.
- R2: Kind 0 (shift left, zero fill) with length n from 1 to 31 gives `operand << n`. Its carry is operand bit 32-n.
- R3: Kind 1 (logical shift right) with length n from 1 to 31 gives `operand >> n`. Its carry is operand bit n-1.
- R4: Kind 2 (arithmetic shift right) with length n from 1 to 31 fills the top n result bits with operand bit 31 and gives `operand >> n` in the rest. Its carry is operand bit n-1.
- R5: Kinds 0 and 1 with a length of 32 or more give a result of 0. At exactly 32 the carry is operand bit 0 for kind 0 and operand bit 31 for kind 1. Above 32 the carry is 0.
- R6: Kind 2 with a length of 32 or more sets every result bit to operand bit 31. Its carry is also operand bit 31.
- R7: Kind 3 (rotate right) with a non-zero length uses the length modulo 32, treating a remainder of 0 as 32. A rotation r of 1 to 31 moves the low r operand bits to the top of the result, with carry operand bit r-1. A rotation of 32 returns the operand, with carry operand bit 31.
- R8: Kind 4 (one-bit rotate through carry) ignores the length and `flagEn`. It gives `{carryIn, operand[31:1]}` as the result, `carryOut` equal to operand bit 0, and `carryValid` of 1.
- R9: For kinds 0 to 3, `carryValid` is 1 exactly when `flagEn` is 1 and the length is non-zero. When `carryValid` is 0, `carryOut` equals `carryIn`. When it is 1, `carryOut` is the carry that R2 to R7 define.
- R10: Kind codes 5, 6 and 7 leave the operand unchanged, hold `carryValid` at 0 and pass `carryIn` to `carryOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand | input | 32 | Value to be shifted |
| shKind | input | 3 | Shift kind: 0 left, 1 logical right, 2 arithmetic right, 3 rotate right, 4 rotate through carry |
| shLen | input | 8 | Shift length |
| carryIn | input | 1 | Current carry flag |
| flagEn | input | 1 | The instruction asks for a flag update |
| result | output | 32 | Shifted value |
| carryOut | output | 1 | Next carry flag value |
| carryValid | output | 1 | Carry flag should be written |

## Verification
The bench builds the block with its default parameters: a 32-bit operand and an 8-bit length. With these values every length from 0 to 255 can be driven. That range covers the zero-length pass-through, the full 1 to 31 range, the exact-32 carry corner and lengths far above 32. For rotates, it also crosses several multiples of 32, where the modulo reduction lands on a full turn. All eight kind codes are swept, with the flag enable both on and off, against a bit-serial reference model. Random operands and carries are then added on top of the sweep.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

  typedef enum logic [2:0] {
    SH_LSL = 3'd0,
    SH_LSR = 3'd1,
    SH_ASR = 3'd2,
    SH_ROR = 3'd3,
    SH_RRX = 3'd4
  } shKind_e;

  // Strobes from the length/kind decoder to the shift datapath
  typedef struct packed {
    logic passThru;   // leave the operand as it is
    logic takeRrx;    // one-bit rotate through carry
    logic mirror;     // left shift done as a right shift on the bit-reversed operand
    logic fillSign;   // fill vacated bits with the sign bit
    logic wrap;       // rotate instead of fill
    logic atWidth;    // effective length equals the word width
    logic pastWidth;  // effective length exceeds the word width
    logic flagWrite;  // carry flag is to be written
  } shStrobe_t;

endpackage

// File: rtl/bshift_ctrl.sv
module bshift_ctrl
  import bshift_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int LEN_W = 8,
  localparam int STG_W = $clog2(WIDTH)
) (
  input  logic [2:0]       kindRaw,
  input  logic [LEN_W-1:0] shLen,
  input  logic             flagEn,
  output shStrobe_t        strobe,
  output logic [STG_W-1:0] amt
);

  logic lenZero;
  logic lowZero;
  logic knownKind;
  int   lenInt;

  assign lenZero = (shLen == '0);
  assign amt     = shLen[STG_W-1:0];
  assign lowZero = (amt == '0);
  assign lenInt  = int'(shLen);

  always_comb begin
    strobe    = '0;
    knownKind = 1'b1;
    case (kindRaw)
      SH_LSL: begin
        strobe.mirror    = 1'b1;
        strobe.atWidth   = (lenInt == WIDTH);
        strobe.pastWidth = (lenInt > WIDTH);
      end
      SH_LSR: begin
        strobe.atWidth   = (lenInt == WIDTH);
        strobe.pastWidth = (lenInt > WIDTH);
      end
      SH_ASR: begin
        strobe.fillSign  = 1'b1;
        strobe.atWidth   = (lenInt == WIDTH);
        strobe.pastWidth = (lenInt > WIDTH);
      end
      SH_ROR: begin
        strobe.wrap      = 1'b1;
        strobe.atWidth   = !lenZero && lowZero;
      end
      SH_RRX: strobe.takeRrx = 1'b1;
      default: knownKind = 1'b0;
    endcase
    strobe.passThru  = !strobe.takeRrx && (lenZero || !knownKind);
    strobe.flagWrite = strobe.takeRrx || (flagEn && !lenZero && knownKind);
  end

endmodule

// File: rtl/bshift_dp.sv
module bshift_dp
  import bshift_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int STG_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] operand,
  input  logic             carryIn,
  input  shStrobe_t        strobe,
  input  logic [STG_W-1:0] amt,
  output logic [WIDTH-1:0] result,
  output logic             carryOut
);

  logic [WIDTH-1:0] opRev;
  logic [WIDTH-1:0] src;
  logic [WIDTH-1:0] stg [0:STG_W];
  logic [WIDTH-1:0] rawRes;
  logic [WIDTH-1:0] rawRev;
  logic [WIDTH-1:0] unRes;
  logic             rawCarry;
  logic             shCarry;
  logic             fillBit;

  generate
    for (genvar k = 0; k < WIDTH; k++) begin : g_rev
      assign opRev[k]  = operand[WIDTH-1-k];
      assign rawRev[k] = rawRes[WIDTH-1-k];
    end
  endgenerate

  assign src     = strobe.mirror ? opRev : operand;
  assign fillBit = strobe.fillSign & src[WIDTH-1];
  assign stg[0]  = src;

  generate
    for (genvar i = 0; i < STG_W; i++) begin : g_stage
      localparam int SH = 1 << i;
      logic [WIDTH-1:0] moved;
      assign moved = strobe.wrap ? {stg[i][SH-1:0], stg[i][WIDTH-1:SH]}
                                 : {{SH{fillBit}}, stg[i][WIDTH-1:SH]};
      assign stg[i+1] = amt[i] ? moved : stg[i];
    end
  endgenerate

  always_comb begin
    if (strobe.atWidth) begin
      rawRes   = strobe.wrap ? src : {WIDTH{fillBit}};
      rawCarry = src[WIDTH-1];
    end else if (strobe.pastWidth) begin
      rawRes   = {WIDTH{fillBit}};
      rawCarry = fillBit;
    end else begin
      rawRes   = stg[STG_W];
      rawCarry = src[amt - 1'b1];
    end
  end

  assign unRes = strobe.mirror ? rawRev : rawRes;

  always_comb begin
    if (strobe.takeRrx) begin
      result  = {carryIn, operand[WIDTH-1:1]};
      shCarry = operand[0];
    end else if (strobe.passThru) begin
      result  = operand;
      shCarry = carryIn;
    end else begin
      result  = unRes;
      shCarry = rawCarry;
    end
    carryOut = strobe.flagWrite ? shCarry : carryIn;
  end

endmodule

// File: rtl/barrel_shifter_top.sv
module barrel_shifter_top
  import bshift_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int LEN_W = 8,
  localparam int STG_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] operand,
  input  logic [2:0]       shKind,
  input  logic [LEN_W-1:0] shLen,
  input  logic             carryIn,
  input  logic             flagEn,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             carryValid
);

  shStrobe_t        strobe;
  logic [STG_W-1:0] amt;

  bshift_ctrl #(.WIDTH(WIDTH), .LEN_W(LEN_W)) u_ctrl (
    .kindRaw (shKind),
    .shLen   (shLen),
    .flagEn  (flagEn),
    .strobe  (strobe),
    .amt     (amt)
  );

  bshift_dp #(.WIDTH(WIDTH)) u_dp (
    .operand  (operand),
    .carryIn  (carryIn),
    .strobe   (strobe),
    .amt      (amt),
    .result   (result),
    .carryOut (carryOut)
  );

  assign carryValid = strobe.flagWrite;

  always_comb begin
    if (shLen == '0 && shKind <= 3'd3)
      a_r1_zero_len: assert (result == operand && !carryValid && carryOut == carryIn);
    if (shKind == 3'd4)
      a_r8_rrx: assert (result[WIDTH-1] == carryIn && carryOut == operand[0] && carryValid);
    if (!carryValid)
      a_r9_carry_hold: assert (carryOut == carryIn);
    if (shKind == 3'd1 && int'(shLen) >= WIDTH)
      a_r5_lsr_clear: assert (result == '0);
    if (shKind == 3'd2 && int'(shLen) >= WIDTH)
      a_r6_asr_sign: assert (result == {WIDTH{operand[WIDTH-1]}});
    if (shKind > 3'd4)
      a_r10_unknown: assert (result == operand && !carryValid);
  end

endmodule

// File: tb/barrel_shifter_top_bench.sv
module barrel_shifter_top_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] operand = '0;
  logic [2:0]  shKind = '0;
  logic [7:0]  shLen = '0;
  logic        carryIn = 1'b0;
  logic        flagEn = 1'b0;
  logic [31:0] result;
  logic        carryOut;
  logic        carryValid;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  barrel_shifter_top u_barrel_shifter_top (
    .operand(operand), .shKind(shKind), .shLen(shLen), .carryIn(carryIn),
    .flagEn(flagEn), .result(result), .carryOut(carryOut), .carryValid(carryValid)
  );

  function automatic string tagOf(int k, int n);
    if (k > 4) return "R10";
    if (k == 4) return "R8";
    if (n == 0) return "R1";
    if (k == 3) return "R7";
    if (n >= 32) return (k == 2) ? "R6" : "R5";
    if (k == 0) return "R2";
    if (k == 1) return "R3";
    return "R4";
  endfunction

  // Bit-serial reference: one position per loop step
  task automatic refModel(input int k, input int n, input logic [31:0] op, input logic ci,
                          input logic en, output logic [31:0] r, output logic c, output logic v);
    logic cc;
    r = op; cc = ci;
    case (k)
      0: for (int s = 0; s < n; s++) begin cc = r[31]; r = r << 1; end
      1: for (int s = 0; s < n; s++) begin cc = r[0]; r = r >> 1; end
      2: for (int s = 0; s < n; s++) begin cc = r[0]; r = {r[31], r[31:1]}; end
      3: for (int s = 0; s < n; s++) begin cc = r[0]; r = {r[0], r[31:1]}; end
      4: begin cc = op[0]; r = {ci, op[31:1]}; end
      default: ;
    endcase
    v = (k == 4) || (en && n != 0 && k <= 3);
    c = v ? cc : ci;
  endtask

  task automatic runOne(input int k, input int n, input logic [31:0] op, input logic ci, input logic en);
    logic [31:0] er; logic ec, ev;
    @(posedge clk);
    shKind = 3'(k); shLen = 8'(n); operand = op; carryIn = ci; flagEn = en;
    refModel(k, n, op, ci, en, er, ec, ev);
    @(negedge clk);
    total++;
    if (result !== er) begin
      bad++;
      $display("FAIL %s result k=%0d n=%0d: actual=%h expected=%h", tagOf(k, n), k, n, result, er);
    end
    total++;
    if (carryOut !== ec || carryValid !== ev) begin
      bad++;
      $display("FAIL R9/%s carry k=%0d n=%0d en=%0b: actual c=%0b v=%0b expected c=%0b v=%0b",
               tagOf(k, n), k, n, en, carryOut, carryValid, ec, ev);
    end
  endtask

  initial begin
    logic [31:0] pats [3];
    pats[0] = 32'h8000_0001; pats[1] = 32'h6A5C_3F91; pats[2] = 32'hF0F0_0F0E;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    total++;
    if (result !== 32'h0 || carryValid !== 1'b0 || carryOut !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset state: actual r=%h v=%0b c=%0b expected r=0 v=0 c=0", result, carryValid, carryOut);
    end
    // R1..R10 sweep over every kind code, length and enable
    for (int k = 0; k < 8; k++)
      for (int n = 0; n < 256; n++)
        for (int e = 0; e < 2; e++)
          for (int p = 0; p < 3; p++)
            runOne(k, n, pats[p], 1'((n + p) & 1), 1'(e));
    // random operands and carries
    for (int t = 0; t < 2000; t++)
      runOne($urandom_range(0, 7), $urandom_range(0, 255), $urandom, 1'($urandom), 1'($urandom));
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule